// File: doc/BRIEF.md
# Branch and Indexed Page-Cross Timing Unit

This unit works out the bus activity that a relative branch or an absolute indexed memory access causes when the computed address may leave the current 256-byte page. A start pulse captures one request. The unit then places on its bus port, one address per clock, every read it would issue: the branch offset fetch and any dummy reads. It finishes with a one-cycle done pulse. That pulse carries the final effective address or the new program counter, together with the total instruction cycle count.

Page crossing is found with a guessed address. The guess keeps the high byte of the starting address and takes the low byte of the true sum. When the guess differs from the true sum, the access has crossed a page. A mode input selects where the dummy read of a crossing goes. In the older variant it goes to the guessed address. In the newer variant it goes to a program-counter address. The unit neither performs the memory access nor evaluates the branch condition; both arrive as inputs.

Top module: `pagecross_timer`

States: `ST_IDLE` (waiting), `ST_OFFSET` (offset fetch), `ST_TAKEN` (taken-branch dummy), `ST_FIX` (branch page-fix dummy), `ST_INDEX` (indexed evaluation slot) and `ST_DONE` (result pulse). Transitions: IDLE→OFFSET on start with `op_branch`=1; IDLE→INDEX on start with `op_branch`=0; OFFSET→TAKEN when taken, otherwise OFFSET→DONE; TAKEN→FIX on a page cross, otherwise TAKEN→DONE; FIX→DONE; INDEX→DONE; DONE→IDLE.

## Requirements
- R1: After reset the unit is idle, with `bus_valid`=0 and `done`=0.
- R2: `start` is sampled only while idle. A `start` pulse or input change while a request is in progress has no effect on the addresses, the result or the cycle count of that request.
- R3: With `op_branch`=1, the cycle after the start edge carries a read at `pc`. If `branch_taken`=0, `done` follows in the next cycle with result `pc`+1 and cycle count 2.
- R4: A taken branch adds a dummy read at `pc`+1. Its result is `pc`+1 plus the sign-extended `br_offset`, modulo 65536. With no page cross the cycle count is 3.
- R5: A taken branch whose target has a different high byte from `pc`+1 adds one more dummy read and has cycle count 4. With `cmos_mode`=0 that read goes to {high byte of `pc`+1, low byte of the target}. With `cmos_mode`=1 it goes to `pc`+1.
- R6: With `op_branch`=0, the result is `base_addr` + `index_val` (unsigned) modulo 65536, and is produced two cycles after the start edge. With no page cross and `always_extra`=0 no bus read is issued and the cycle count is 4.
- R7: An indexed access whose sum has a different high byte from `base_addr` issues exactly one dummy read and has cycle count 5. With `cmos_mode`=0 the read goes to {high byte of `base_addr`, low byte of the sum}. With `cmos_mode`=1 it goes to `pc`.
- R8: With `always_extra`=1 and no page cross, an indexed access issues one dummy read at the true sum and has cycle count 5. A page cross with `always_extra`=1 still issues only the single dummy of R7.
- R9: `done` lasts exactly one cycle, is never high together with `bus_valid`, and the unit is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| op_branch | input | 1 | 1 = relative branch, 0 = absolute indexed access |
| cmos_mode | input | 1 | 0 = older dummy-read targets, 1 = newer targets |
| always_extra | input | 1 | Indexed access always spends the extra cycle (store or read-modify-write) |
| branch_taken | input | 1 | Branch condition outcome |
| pc | input | 16 | Address of the branch offset byte, or program counter for an indexed access |
| base_addr | input | 16 | Indexed base address |
| index_val | input | 8 | Index register value |
| br_offset | input | 8 | Signed branch displacement |
| bus_valid | output | 1 | A bus read is presented this cycle |
| bus_addr | output | 16 | Bus read address (zero when `bus_valid` is 0) |
| done | output | 1 | Result pulse |
| result_addr | output | 16 | New PC or effective address, valid with `done` |
| cycle_count | output | 3 | Total instruction cycles, valid with `done` |

## Verification
The first bus address is due in the cycle right after the start edge. Each further dummy read follows one cycle later, and `done` with its result and cycle count comes one cycle after the last address. For an indexed access the evaluation slot always takes the first cycle after start, whether or not it carries a read, so `done` is due exactly two cycles after the start edge. The bench builds, for every request, a queue with one expected entry per cycle from the start edge on. It compares valid, address, done, result and count at every falling edge against the next entry, and then checks that the following cycle is idle.

// File: rtl/pct_pkg.sv
package pct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFFSET,
        ST_TAKEN,
        ST_FIX,
        ST_INDEX,
        ST_DONE
    } pct_state_e;

    typedef enum logic [1:0] {
        SEL_PC,
        SEL_PC_NEXT,
        SEL_GUESS,
        SEL_TRUE
    } pct_sel_e;

endpackage

// File: rtl/page_cross_calc.sv
module page_cross_calc #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 8,
    parameter int ADD_W      = 8,
    parameter bit SIGNED_ADD = 1'b0
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADD_W-1:0]  addend,
    output logic [ADDR_W-1:0] sum_addr,
    output logic [ADDR_W-1:0] guess_addr,
    output logic              crossed
);
    localparam int EXT_W = ADDR_W - ADD_W;

    logic [ADDR_W-1:0] addend_ext;

    generate
        if (SIGNED_ADD) begin : g_sext
            assign addend_ext = {{EXT_W{addend[ADD_W-1]}}, addend};
        end else begin : g_zext
            assign addend_ext = {{EXT_W{1'b0}}, addend};
        end
    endgenerate

    assign sum_addr   = start_addr + addend_ext;
    assign guess_addr = {start_addr[ADDR_W-1:PAGE_W], sum_addr[PAGE_W-1:0]};
    assign crossed    = (guess_addr != sum_addr);

endmodule

// File: rtl/pct_fsm.sv
module pct_fsm
    import pct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       op_branch,
    input  logic       taken_q,
    input  logic       cmos_q,
    input  logic       extra_q,
    input  logic       br_cross,
    input  logic       ix_cross,
    output pct_state_e state_o,
    output logic       bus_valid,
    output pct_sel_e   addr_sel,
    output logic       done
);
    pct_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        bus_valid = 1'b0;
        addr_sel  = SEL_PC;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = op_branch ? ST_OFFSET : ST_INDEX;
                end
            end
            ST_OFFSET: begin
                bus_valid = 1'b1;
                addr_sel  = SEL_PC;
                state_d   = taken_q ? ST_TAKEN : ST_DONE;
            end
            ST_TAKEN: begin
                bus_valid = 1'b1;
                addr_sel  = SEL_PC_NEXT;
                state_d   = br_cross ? ST_FIX : ST_DONE;
            end
            ST_FIX: begin
                bus_valid = 1'b1;
                addr_sel  = cmos_q ? SEL_PC_NEXT : SEL_GUESS;
                state_d   = ST_DONE;
            end
            ST_INDEX: begin
                bus_valid = ix_cross || extra_q;
                if (ix_cross) begin
                    addr_sel = cmos_q ? SEL_PC : SEL_GUESS;
                end else begin
                    addr_sel = SEL_TRUE;
                end
                state_d = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pagecross_timer.sv
module pagecross_timer
    import pct_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 8,
    parameter int IDX_W       = 8,
    parameter int OFF_W       = 8,
    parameter int CYC_W       = 3,
    parameter int IX_BASE_CYC = 4,
    parameter int BR_BASE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_branch,
    input  logic              cmos_mode,
    input  logic              always_extra,
    input  logic              branch_taken,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  index_val,
    input  logic [OFF_W-1:0]  br_offset,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              done,
    output logic [ADDR_W-1:0] result_addr,
    output logic [CYC_W-1:0]  cycle_count
);
    localparam logic [CYC_W-1:0] IX_BASE = CYC_W'(IX_BASE_CYC);
    localparam logic [CYC_W-1:0] BR_BASE = CYC_W'(BR_BASE_CYC);

    pct_state_e        state;
    pct_sel_e          addr_sel;
    logic              fsm_idle;
    logic              accept;

    logic              kind_q, cmos_q, extra_q, taken_q;
    logic [ADDR_W-1:0] pc_q, base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [OFF_W-1:0]  off_q;
    logic [CYC_W-1:0]  extra_cnt_q;

    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] br_sum, br_guess, ix_sum, ix_guess;
    logic              br_cross, ix_cross;
    logic [ADDR_W-1:0] addr_mux;

    assign fsm_idle = (state == ST_IDLE);
    assign accept   = start && fsm_idle;
    assign pc_next  = pc_q + ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= 1'b0;
            cmos_q  <= 1'b0;
            extra_q <= 1'b0;
            taken_q <= 1'b0;
            pc_q    <= '0;
            base_q  <= '0;
            idx_q   <= '0;
            off_q   <= '0;
        end else if (accept) begin
            kind_q  <= op_branch;
            cmos_q  <= cmos_mode;
            extra_q <= always_extra;
            taken_q <= branch_taken;
            pc_q    <= pc;
            base_q  <= base_addr;
            idx_q   <= index_val;
            off_q   <= br_offset;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            extra_cnt_q <= '0;
        end else if (accept) begin
            extra_cnt_q <= '0;
        end else if (bus_valid) begin
            extra_cnt_q <= extra_cnt_q + CYC_W'(1);
        end
    end

    page_cross_calc #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ADD_W(OFF_W), .SIGNED_ADD(1'b1)
    ) u_branch_calc (
        .start_addr(pc_next),
        .addend    (off_q),
        .sum_addr  (br_sum),
        .guess_addr(br_guess),
        .crossed   (br_cross)
    );

    page_cross_calc #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ADD_W(IDX_W), .SIGNED_ADD(1'b0)
    ) u_index_calc (
        .start_addr(base_q),
        .addend    (idx_q),
        .sum_addr  (ix_sum),
        .guess_addr(ix_guess),
        .crossed   (ix_cross)
    );

    pct_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_branch(op_branch),
        .taken_q  (taken_q),
        .cmos_q   (cmos_q),
        .extra_q  (extra_q),
        .br_cross (br_cross),
        .ix_cross (ix_cross),
        .state_o  (state),
        .bus_valid(bus_valid),
        .addr_sel (addr_sel),
        .done     (done)
    );

    always_comb begin
        unique case (addr_sel)
            SEL_PC:      addr_mux = pc_q;
            SEL_PC_NEXT: addr_mux = pc_next;
            SEL_GUESS:   addr_mux = kind_q ? br_guess : ix_guess;
            SEL_TRUE:    addr_mux = ix_sum;
            default:     addr_mux = pc_q;
        endcase
    end

    assign bus_addr = bus_valid ? addr_mux : '0;

    always_comb begin
        result_addr = '0;
        cycle_count = '0;
        if (done) begin
            if (kind_q) begin
                result_addr = taken_q ? br_sum : pc_next;
                cycle_count = BR_BASE + extra_cnt_q;
            end else begin
                result_addr = ix_sum;
                cycle_count = IX_BASE + extra_cnt_q;
            end
        end
    end

endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
    parameter int ADDR_W = 16,
    parameter int CYC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op_branch,
    input logic              branch_taken,
    input logic [ADDR_W-1:0] pc,
    input logic              fsm_idle,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done,
    input logic [ADDR_W-1:0] result_addr,
    input logic [CYC_W-1:0]  cycle_count
);
    logic [ADDR_W-1:0] pc_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_seen <= '0;
        end else if (start && fsm_idle) begin
            pc_seen <= pc;
        end
    end

    AST_OFFSET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && fsm_idle && op_branch) |=> (bus_valid && bus_addr == $past(pc))); // R3

    AST_NOT_TAKEN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && fsm_idle && op_branch && !branch_taken) |=> ##1
        (done && cycle_count == CYC_W'(2) && result_addr == ADDR_W'(pc_seen + ADDR_W'(1)))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> (!bus_valid && !done)); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && fsm_idle)); // R9

    AST_DONE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_valid); // R9

    AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycle_count >= CYC_W'(2) && cycle_count <= CYC_W'(5))); // R7

endmodule

bind pagecross_timer pct_checker #(
    .ADDR_W(ADDR_W), .CYC_W(CYC_W)
) u_pct_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_branch   (op_branch),
    .branch_taken(branch_taken),
    .pc          (pc),
    .fsm_idle    (fsm_idle),
    .bus_valid   (bus_valid),
    .bus_addr    (bus_addr),
    .done        (done),
    .result_addr (result_addr),
    .cycle_count (cycle_count)
);

// File: tb/pagecross_timer_bench.sv
module pagecross_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_branch = 1'b0;
    logic        cmos_mode = 1'b0;
    logic        always_extra = 1'b0;
    logic        branch_taken = 1'b0;
    logic [15:0] pc = '0;
    logic [15:0] base_addr = '0;
    logic [7:0]  index_val = '0;
    logic [7:0]  br_offset = '0;
    logic        bus_valid;
    logic [15:0] bus_addr;
    logic        done;
    logic [15:0] result_addr;
    logic [2:0]  cycle_count;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          v;
        logic [15:0] a;
        bit          d;
        logic [15:0] r;
        int          c;
    } slot_t;

    slot_t exp_q[$];

    always #10 clk = ~clk;

    pagecross_timer u_pagecross_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .op_branch(op_branch),
        .cmos_mode(cmos_mode), .always_extra(always_extra),
        .branch_taken(branch_taken), .pc(pc), .base_addr(base_addr),
        .index_val(index_val), .br_offset(br_offset),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .done(done),
        .result_addr(result_addr), .cycle_count(cycle_count)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Behavioural model: one entry per cycle after the start edge.
    task automatic build(bit br, bit cm, bit ax, bit tk, logic [15:0] p,
                         logic [15:0] b, logic [7:0] ix, logic [7:0] off);
        slot_t s;
        int    n;
        int    p1, tgt, ea, guess;
        exp_q.delete();
        if (br) begin
            p1 = (p + 1) % 65536;
            s = '{1, p[15:0], 0, 0, 0}; exp_q.push_back(s); n = 1;
            tgt = p1;
            if (tk) begin
                tgt = (p1 + $signed(off) + 65536) % 65536;
                s = '{1, p1[15:0], 0, 0, 0}; exp_q.push_back(s); n++;
                if ((tgt / 256) != (p1 / 256)) begin
                    guess = (p1 / 256) * 256 + (tgt % 256);
                    s = '{1, cm ? p1[15:0] : guess[15:0], 0, 0, 0};
                    exp_q.push_back(s); n++;
                end
            end
            s = '{0, 0, 1, tgt[15:0], 1 + n}; exp_q.push_back(s);
        end else begin
            ea = (b + ix) % 65536;
            guess = (b / 256) * 256 + (ea % 256);
            if ((ea / 256) != (b / 256)) begin
                s = '{1, cm ? p : guess[15:0], 0, 0, 0}; n = 1;
            end else if (ax) begin
                s = '{1, ea[15:0], 0, 0, 0}; n = 1;
            end else begin
                s = '{0, 0, 0, 0, 0}; n = 0;
            end
            exp_q.push_back(s);
            s = '{0, 0, 1, ea[15:0], 4 + n}; exp_q.push_back(s);
        end
    endtask

    task automatic run_op(string req, bit br, bit cm, bit ax, bit tk,
                          logic [15:0] p, logic [15:0] b, logic [7:0] ix,
                          logic [7:0] off, bit hold);
        int k;
        build(br, cm, ax, tk, p, b, ix, off);
        @(negedge clk);
        op_branch = br; cmos_mode = cm; always_extra = ax; branch_taken = tk;
        pc = p; base_addr = b; index_val = ix; br_offset = off; start = 1'b1;
        k = 0;
        while (exp_q.size() > 0) begin
            slot_t e;
            e = exp_q.pop_front();
            @(negedge clk);
            check(bus_valid == e.v, req, $sformatf("slot %0d valid", k), bus_valid, e.v);
            if (e.v)
                check(bus_addr == e.a, req, $sformatf("slot %0d addr", k), bus_addr, e.a);
            check(done == e.d, req, $sformatf("slot %0d done", k), done, e.d);
            if (e.d) begin
                check(result_addr == e.r, req, "result", result_addr, e.r);
                check(int'(cycle_count) == e.c, req, "cycles", cycle_count, e.c);
            end
            if (hold && exp_q.size() > 0) begin
                // R2: new request presented while busy must be ignored
                op_branch = ~br; cmos_mode = ~cm; always_extra = ~ax;
                branch_taken = ~tk; pc = ~p; base_addr = ~b;
                index_val = ~ix; br_offset = ~off;
            end else begin
                start = 1'b0;
            end
            k++;
        end
        @(negedge clk);
        check(!bus_valid && !done, "R9", "idle after done", {bus_valid, done}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!bus_valid && !done, "R1", "reset outputs", {bus_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_valid && !done, "R1", "idle after reset", {bus_valid, done}, 0);

        run_op("R3", 1, 0, 0, 0, 16'h1234, 16'h0, 8'h00, 8'h40, 0);
        run_op("R4", 1, 0, 0, 1, 16'h1210, 16'h0, 8'h00, 8'h10, 0);
        run_op("R4", 1, 1, 0, 1, 16'h1280, 16'h0, 8'h00, 8'hF0, 0);
        run_op("R5", 1, 0, 0, 1, 16'h12F0, 16'h0, 8'h00, 8'h20, 0);
        run_op("R5", 1, 1, 0, 1, 16'h12F0, 16'h0, 8'h00, 8'h20, 0);
        run_op("R5", 1, 0, 0, 1, 16'h1205, 16'h0, 8'h00, 8'h80, 0);
        run_op("R5", 1, 0, 0, 1, 16'hFFFE, 16'h0, 8'h00, 8'h05, 0);
        run_op("R6", 0, 0, 0, 0, 16'h4000, 16'h2010, 8'h05, 8'h00, 0);
        run_op("R6", 0, 0, 0, 0, 16'h4000, 16'hFFF0, 8'h20, 8'h00, 0);
        run_op("R7", 0, 0, 0, 0, 16'h4000, 16'h20F0, 8'h20, 8'h00, 0);
        run_op("R7", 0, 1, 0, 0, 16'h4321, 16'h20F0, 8'h20, 8'h00, 0);
        run_op("R8", 0, 0, 1, 0, 16'h4000, 16'h3000, 8'h7F, 8'h00, 0);
        run_op("R8", 0, 1, 1, 0, 16'h5555, 16'h30FF, 8'hFF, 8'h00, 0);
        run_op("R8", 0, 0, 1, 0, 16'h5555, 16'h30FF, 8'h01, 8'h00, 0);
        run_op("R2", 1, 0, 0, 1, 16'h12F0, 16'h0, 8'h00, 8'h20, 1);
        run_op("R2", 0, 1, 0, 0, 16'h6000, 16'h2010, 8'h05, 8'h00, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule